// File: doc/BRIEF.md
# SIMD Element Mask Unit

This unit performs four mask operations on a 128-bit vector operand, one operation per transfer, with the element width chosen per transfer. It can do four things. It can collect the top bit of every element into a small scalar mask. It can widen each element's top bit into a full-element mask. It can turn a scalar bit mask into a full-width element mask. It can count the elements whose top bit equals a selector bit.

Elements are numbered from the left in every mode. Element 0 is the one that holds vector bit 127. The count is returned left-justified in a 64-bit word, so its top byte is the number of bytes covered by the matching elements. That value can be used directly as a byte length.

Operands enter through a valid/ready handshake and the result leaves through a second one, with a single register stage between them. A transfer is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. While the held result is not taken (`out_valid` high, `out_ready` low), `in_ready` stays low and the held result does not change. When the held result is taken, or the register is empty, a new operand can be accepted in the same cycle. This gives one result per cycle with no bubbles.

Top module: `simd_mask_unit`

## Requirements
- R1: Opcode 0 (gather): with E elements, result scalar bit (E-1-i) equals the most-significant bit of element i. All higher scalar bits are zero. Size codes 0, 1, 2, 3 and 4 select 8-, 16-, 32-, 64- and 128-bit elements, so E is 16, 8, 4, 2 or 1.
- R2: Opcode 1 (spread): each result element is all ones when that element's most-significant bit is 1, and all zeros otherwise. This holds for every size code from 0 to 4.
- R3: Opcode 2 (build): result element i is all ones when `in_scalar` bit (E-1-i) is 1, and all zeros otherwise. Only the low E scalar bits are used, so size code 4 fills all 128 bits from scalar bit 0.
- R4: Opcode 3 (tally): the unit counts the elements whose most-significant bit equals `in_sel`. Result bits 63:56 hold the count multiplied by the element size in bytes, with size codes 0 to 3 only. Bits 55:0 are zero.
- R5: Size codes 5 to 7 with any opcode, and size code 4 with opcode 3, are illegal. They raise `out_illegal` and return zero on both result outputs.
- R6: Opcodes 1 and 2 return a zero scalar, and opcodes 0 and 3 return a zero vector. An operand that the chosen operation does not use has no effect on the result.
- R7: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. While stalled, all outputs hold their values, and the output data never changes without an accepted transfer.
- R8: Reset clears `out_valid` and leaves `in_ready` high.
- R9: A transfer accepted at a rising edge shows its result, with `out_valid` high, right after that edge. With `in_valid` low and `out_ready` high, `out_valid` falls after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand transfer offered |
| in_ready | output | 1 | Unit can take an operand |
| in_op | input | 2 | Operation code (0 gather, 1 spread, 2 build, 3 tally) |
| in_esize | input | 3 | Element size code (0 byte to 4 quadword) |
| in_vec | input | 128 | Vector operand, bit 127 is the left end of element 0 |
| in_scalar | input | 64 | Scalar bit mask for the build operation |
| in_sel | input | 1 | Top-bit value counted by the tally operation |
| out_valid | output | 1 | Result held and offered |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | 128 | Vector result |
| out_scalar | output | 64 | Scalar result |
| out_illegal | output | 1 | Illegal size and opcode combination |

## Verification
Two events can fall in the same cycle: the consumer taking the held result and the unit accepting the next operand. The stimulus table provokes this by streaming its rows back to back while `in_valid` and `out_ready` stay high. Each result is judged at the falling edge after its acceptance, so a dropped, repeated or shifted result shows up as a mismatch on the next row. A directed stall then holds `out_ready` low while a second operand waits. The bench confirms that `in_ready` stays low and the first result is kept. It then releases the stall and checks that the waiting operand goes through exactly once.

// File: rtl/simd_mask_pkg.sv
package simd_mask_pkg;

  localparam int DEF_VEC_W  = 128;
  localparam int DEF_SCL_W  = 64;
  localparam int DEF_MIN_EW = 8;
  localparam int DEF_ESZ_W  = 3;
  localparam int TOP_W      = 8;   // width of the left-justified length field

  typedef enum logic [1:0] {
    OP_GATHER = 2'd0,
    OP_SPREAD = 2'd1,
    OP_BUILD  = 2'd2,
    OP_TALLY  = 2'd3
  } mask_op_e;

  typedef enum logic [2:0] {
    SZ_BYTE = 3'd0,
    SZ_HALF = 3'd1,
    SZ_WORD = 3'd2,
    SZ_DBL  = 3'd3,
    SZ_QUAD = 3'd4
  } elem_size_e;

endpackage

// File: rtl/simd_msb_gather.sv
// Collects the top bit of each element for every supported element size and
// selects the set for the requested size. Bit j of the result is the top bit
// of the element at position j counted from the right end of the vector.
module simd_msb_gather #(
  parameter int VEC_W  = simd_mask_pkg::DEF_VEC_W,
  parameter int MIN_EW = simd_mask_pkg::DEF_MIN_EW,
  parameter int ESZ_W  = simd_mask_pkg::DEF_ESZ_W,
  localparam int MAXNE = VEC_W / MIN_EW,
  localparam int NSZ   = $clog2(MAXNE) + 1
) (
  input  logic [VEC_W-1:0] vec_i,
  input  logic [ESZ_W-1:0] esize_i,
  output logic [MAXNE-1:0] msbs_o
);

  logic [MAXNE-1:0] by_size [NSZ];

  for (genvar s = 0; s < NSZ; s++) begin : g_size
    localparam int EW = MIN_EW << s;
    localparam int NE = VEC_W / EW;
    logic [MAXNE-1:0] lanes;
    for (genvar j = 0; j < NE; j++) begin : g_lane
      assign lanes[j] = vec_i[j*EW + EW - 1];
    end
    if (NE < MAXNE) begin : g_pad
      assign lanes[MAXNE-1:NE] = '0;
    end
    assign by_size[s] = lanes;
  end

  always_comb begin
    msbs_o = '0;
    for (int s = 0; s < NSZ; s++) begin
      if (esize_i == ESZ_W'(s)) msbs_o = by_size[s];
    end
  end

endmodule

// File: rtl/simd_bit_spread.sv
// Widens mask bit j across the element at position j from the right end of
// the vector. Serves both the spread and the build operation.
module simd_bit_spread #(
  parameter int VEC_W  = simd_mask_pkg::DEF_VEC_W,
  parameter int MIN_EW = simd_mask_pkg::DEF_MIN_EW,
  parameter int ESZ_W  = simd_mask_pkg::DEF_ESZ_W,
  localparam int MAXNE = VEC_W / MIN_EW,
  localparam int NSZ   = $clog2(MAXNE) + 1
) (
  input  logic [MAXNE-1:0] mask_i,
  input  logic [ESZ_W-1:0] esize_i,
  output logic [VEC_W-1:0] vec_o
);

  logic [VEC_W-1:0] by_size [NSZ];

  for (genvar s = 0; s < NSZ; s++) begin : g_size
    localparam int EW = MIN_EW << s;
    localparam int NE = VEC_W / EW;
    logic [VEC_W-1:0] wide;
    for (genvar j = 0; j < NE; j++) begin : g_lane
      assign wide[j*EW +: EW] = {EW{mask_i[j]}};
    end
    assign by_size[s] = wide;
  end

  always_comb begin
    vec_o = '0;
    for (int s = 0; s < NSZ; s++) begin
      if (esize_i == ESZ_W'(s)) vec_o = by_size[s];
    end
  end

endmodule

// File: rtl/simd_msb_tally.sv
// Counts lanes whose top bit equals the selector and places the byte length
// of the matching elements in the top byte of the scalar result.
module simd_msb_tally #(
  parameter int VEC_W  = simd_mask_pkg::DEF_VEC_W,
  parameter int SCL_W  = simd_mask_pkg::DEF_SCL_W,
  parameter int MIN_EW = simd_mask_pkg::DEF_MIN_EW,
  parameter int ESZ_W  = simd_mask_pkg::DEF_ESZ_W,
  localparam int MAXNE = VEC_W / MIN_EW,
  localparam int NSZ   = $clog2(MAXNE) + 1,
  localparam int CNT_W = $clog2(MAXNE + 1),
  localparam int TOP_W = simd_mask_pkg::TOP_W
) (
  input  logic [MAXNE-1:0] msbs_i,
  input  logic [ESZ_W-1:0] esize_i,
  input  logic             sel_i,
  output logic [SCL_W-1:0] scl_o
);

  logic [MAXNE-1:0] lane_en_by_size [NSZ];
  logic [MAXNE-1:0] lane_en;
  logic [MAXNE-1:0] hits;
  logic [CNT_W-1:0] count;
  logic [TOP_W-1:0] length;

  for (genvar s = 0; s < NSZ; s++) begin : g_size
    localparam int NE = MAXNE >> s;
    if (NE == MAXNE) begin : g_full
      assign lane_en_by_size[s] = '1;
    end else begin : g_part
      assign lane_en_by_size[s] = MAXNE'((1 << NE) - 1);
    end
  end

  always_comb begin
    lane_en = '0;
    for (int s = 0; s < NSZ; s++) begin
      if (esize_i == ESZ_W'(s)) lane_en = lane_en_by_size[s];
    end
    hits  = (sel_i ? msbs_i : ~msbs_i) & lane_en;
    count = '0;
    for (int j = 0; j < MAXNE; j++) begin
      count = count + CNT_W'(hits[j]);
    end
    length = TOP_W'(count) << esize_i;
    scl_o  = {length, {(SCL_W-TOP_W){1'b0}}};
  end

endmodule

// File: rtl/simd_out_stage.sv
// Single register slice with valid/ready on both sides.
module simd_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);

  assign in_ready_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      if (in_ready_o) out_valid_o <= in_valid_i;
      if (in_valid_i && in_ready_o) out_data_o <= in_data_i;
    end
  end

endmodule

// File: rtl/simd_mask_unit.sv
module simd_mask_unit #(
  parameter int VEC_W  = simd_mask_pkg::DEF_VEC_W,
  parameter int SCL_W  = simd_mask_pkg::DEF_SCL_W,
  parameter int MIN_EW = simd_mask_pkg::DEF_MIN_EW,
  parameter int ESZ_W  = simd_mask_pkg::DEF_ESZ_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_op,
  input  logic [ESZ_W-1:0] in_esize,
  input  logic [VEC_W-1:0] in_vec,
  input  logic [SCL_W-1:0] in_scalar,
  input  logic             in_sel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_vec,
  output logic [SCL_W-1:0] out_scalar,
  output logic             out_illegal
);
  import simd_mask_pkg::*;

  localparam int MAXNE  = VEC_W / MIN_EW;
  localparam int NSZ    = $clog2(MAXNE) + 1;
  localparam logic [ESZ_W-1:0] WIDEST = ESZ_W'(NSZ - 1);
  localparam int RES_W  = VEC_W + SCL_W + 1;

  mask_op_e         op;
  logic [MAXNE-1:0] msbs;
  logic [VEC_W-1:0] spread_vec;
  logic [VEC_W-1:0] build_vec;
  logic [SCL_W-1:0] tally_scl;
  logic             illegal;
  logic [VEC_W-1:0] res_vec;
  logic [SCL_W-1:0] res_scl;
  logic [RES_W-1:0] res_packed;
  logic [RES_W-1:0] held_packed;

  assign op = mask_op_e'(in_op);

  simd_msb_gather #(.VEC_W(VEC_W), .MIN_EW(MIN_EW), .ESZ_W(ESZ_W)) i_gather (
    .vec_i   (in_vec),
    .esize_i (in_esize),
    .msbs_o  (msbs)
  );

  simd_bit_spread #(.VEC_W(VEC_W), .MIN_EW(MIN_EW), .ESZ_W(ESZ_W)) i_spread (
    .mask_i  (msbs),
    .esize_i (in_esize),
    .vec_o   (spread_vec)
  );

  simd_bit_spread #(.VEC_W(VEC_W), .MIN_EW(MIN_EW), .ESZ_W(ESZ_W)) i_build (
    .mask_i  (in_scalar[MAXNE-1:0]),
    .esize_i (in_esize),
    .vec_o   (build_vec)
  );

  simd_msb_tally #(.VEC_W(VEC_W), .SCL_W(SCL_W), .MIN_EW(MIN_EW), .ESZ_W(ESZ_W)) i_tally (
    .msbs_i  (msbs),
    .esize_i (in_esize),
    .sel_i   (in_sel),
    .scl_o   (tally_scl)
  );

  // Illegal: size code beyond the widest element, or tally on the widest one.
  assign illegal = (in_esize > WIDEST) || (op == OP_TALLY && in_esize == WIDEST);

  always_comb begin
    res_vec = '0;
    res_scl = '0;
    if (!illegal) begin
      unique case (op)
        OP_GATHER: res_scl = SCL_W'(msbs);
        OP_SPREAD: res_vec = spread_vec;
        OP_BUILD:  res_vec = build_vec;
        OP_TALLY:  res_scl = tally_scl;
        default:   res_vec = '0;
      endcase
    end
  end

  assign res_packed = {res_vec, res_scl, illegal};

  simd_out_stage #(.W(RES_W)) i_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_data_i   (res_packed),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_data_o  (held_packed)
  );

  assign {out_vec, out_scalar, out_illegal} = held_packed;

endmodule

// File: rtl/simd_mask_unit_chk.sv
module simd_mask_unit_chk #(
  parameter int VEC_W = simd_mask_pkg::DEF_VEC_W,
  parameter int SCL_W = simd_mask_pkg::DEF_SCL_W,
  parameter int ESZ_W = simd_mask_pkg::DEF_ESZ_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_op,
  input logic [ESZ_W-1:0] in_esize,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_vec,
  input logic [SCL_W-1:0] out_scalar,
  input logic             out_illegal
);
  import simd_mask_pkg::*;

  logic take;
  assign take = in_valid && in_ready;

  a_r7_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vec) &&
                                  $stable(out_scalar) && $stable(out_illegal)));

  a_r7_no_change_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(out_vec) && $stable(out_scalar) && $stable(out_illegal)));

  a_r9_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  a_r1_gather_width: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == OP_GATHER) |=> (out_scalar[SCL_W-1:16] == '0));

  a_r4_tally_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == OP_TALLY) |=> (out_scalar[SCL_W-9:0] == '0));

  a_r5_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_vec == '0 && out_scalar == '0));

  a_r6_vector_ops_zero_scl: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_op == OP_SPREAD || in_op == OP_BUILD)) |=> (out_scalar == '0));

  a_r6_scalar_ops_zero_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_op == OP_GATHER || in_op == OP_TALLY)) |=> (out_vec == '0));

endmodule

bind simd_mask_unit simd_mask_unit_chk #(.VEC_W(VEC_W), .SCL_W(SCL_W), .ESZ_W(ESZ_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .in_esize    (in_esize),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_vec     (out_vec),
  .out_scalar  (out_scalar),
  .out_illegal (out_illegal)
);

// File: tb/test_simd_mask_unit.sv
module test_simd_mask_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_op = '0;
  logic [2:0]   in_esize = '0;
  logic [127:0] in_vec = '0;
  logic [63:0]  in_scalar = '0;
  logic         in_sel = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_vec;
  logic [63:0]  out_scalar;
  logic         out_illegal;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_mask_unit i_simd_mask_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_esize(in_esize), .in_vec(in_vec), .in_scalar(in_scalar),
    .in_sel(in_sel), .out_valid(out_valid), .out_ready(out_ready),
    .out_vec(out_vec), .out_scalar(out_scalar), .out_illegal(out_illegal)
  );

  localparam logic [127:0] V1 = 128'h80FF_7F00_8001_0080_FFFF_0000_8000_7FFF;
  localparam logic [127:0] V2 = 128'h7FFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF;
  localparam logic [127:0] XB = 128'hFFFF_0000_FF00_00FF_FFFF_0000_FF00_00FF;
  localparam logic [63:0]  ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  localparam int NV = 22;
  // rows 0-4 R1 (and R6), 5-7 R2, 8-12 R3, 13-18 R4, 19-21 R5
  localparam int T_REQ [NV] = '{1,1,1,1,1, 2,2,2, 3,3,3,3,3, 4,4,4,4,4,4, 5,5,5};
  localparam logic [1:0] T_OP [NV] = '{0,0,0,0,0, 1,1,1, 2,2,2,2,2, 3,3,3,3,3,3, 3,0,1};
  localparam logic [2:0] T_SZ [NV] = '{0,1,2,3,4, 0,1,4, 0,2,3,1,4, 0,1,2,2,3,0, 4,5,7};
  localparam logic [127:0] T_VEC [NV] = '{V1,V1,V1,V1,V1, V1,V1,V2,
    V2,V1,V1,V1,V1, V1,V1,V1,V1,V1,V2, V1,V1,V1};
  localparam logic [63:0] T_SCL [NV] = '{ONES,0,0,0,0, ONES,0,0,
    64'hC9C9, 64'h5, 64'h2, 64'hFFFF_FFFF_FFFF_FF81, 64'hFFFF_FFFF_FFFF_FFFE,
    0,0,0,0,0,0, 0,0,ONES};
  localparam logic T_SEL [NV] = '{0,0,0,0,0, 0,0,0, 0,0,0,0,0, 1,1,1,0,1,0, 1,0,0};
  localparam logic [127:0] E_VEC [NV] = '{0,0,0,0,0,
    XB, 128'hFFFF_0000_FFFF_0000_FFFF_0000_FFFF_0000, 0,
    XB, 128'h0000_0000_FFFF_FFFF_0000_0000_FFFF_FFFF,
    128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0000,
    128'hFFFF_0000_0000_0000_0000_0000_0000_FFFF, 0,
    0,0,0,0,0,0, 0,0,0};
  localparam logic [63:0] E_SCL [NV] = '{64'hC9C9, 64'hAA, 64'hF, 64'h3, 64'h1,
    0,0,0, 0,0,0,0,0,
    64'h0800_0000_0000_0000, 64'h0800_0000_0000_0000, 64'h1000_0000_0000_0000,
    64'h0, 64'h1000_0000_0000_0000, 64'h0100_0000_0000_0000,
    0,0,0};
  localparam logic E_ILL [NV] = '{0,0,0,0,0, 0,0,0, 0,0,0,0,0, 0,0,0,0,0,0, 1,1,1};

  task automatic check(input string req, input logic ok,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [2:0] sz, input logic [127:0] v,
                       input logic [63:0] s, input logic sel);
    in_valid = 1'b1; in_op = op; in_esize = sz; in_vec = v; in_scalar = s; in_sel = sel;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired got 0 expected 1");
    finish_run();
  end

  initial begin
    // R8: state during and after reset
    repeat (3) @(negedge clk);
    check("R8 valid in reset", out_valid == 1'b0, 128'(out_valid), 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 ready after reset", in_ready == 1'b1 && out_valid == 1'b0,
          {126'h0, in_ready, out_valid}, 128'h2);

    // Table: back to back, consume and accept in the same cycle (R9, R7)
    for (int i = 0; i <= NV; i++) begin
      if (i > 0) begin
        string tag;
        tag = $sformatf("R%0d row %0d", T_REQ[i-1], i-1);
        check({tag, " valid"}, out_valid == 1'b1, 128'(out_valid), 128'h1);
        check({tag, " vec"}, out_vec == E_VEC[i-1], out_vec, E_VEC[i-1]);
        check({tag, " scalar/illegal"},
              out_scalar == E_SCL[i-1] && out_illegal == E_ILL[i-1],
              {63'h0, out_illegal, out_scalar}, {63'h0, E_ILL[i-1], E_SCL[i-1]});
      end
      if (i < NV) drive(T_OP[i], T_SZ[i], T_VEC[i], T_SCL[i], T_SEL[i]);
      else in_valid = 1'b0;
      @(negedge clk);
    end

    // R9: drained after an idle cycle
    check("R9 drain", out_valid == 1'b0, 128'(out_valid), 128'h0);

    // R7: stall holds the result and blocks the next operand
    out_ready = 1'b0;
    drive(2'd0, 3'd0, V1, 64'h0, 1'b0);          // gather bytes -> C9C9
    @(negedge clk);
    drive(2'd2, 3'd4, 128'h0, 64'h1, 1'b0);      // build quad -> all ones
    check("R7 ready low in stall", in_ready == 1'b0, 128'(in_ready), 128'h0);
    repeat (2) @(negedge clk);
    check("R7 held result", out_valid && out_scalar == 64'hC9C9 && out_vec == '0,
          128'(out_scalar), 128'hC9C9);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 waiting operand passed", out_valid && out_vec == '1 && out_scalar == '0,
          out_vec, '1);
    in_vec = V2; in_op = 2'd1;
    @(negedge clk);
    check("R7 no update without transfer", out_valid == 1'b0 && out_vec == '1,
          out_vec, '1);

    // R8: reset in mid-run clears the output
    drive(2'd1, 3'd0, V1, 64'h0, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R8 reset mid-run", out_valid == 1'b0, 128'(out_valid), 128'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule